// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns an input address into a 52-bit physical address by reading a chain of translation tables from memory. Each table is 4 KB, naturally aligned, and holds 512 entries of 64 bits. A walk goes four or five levels deep, chosen by a mode bit. The first table's base comes from a root pointer. Each later table's base comes from the entry just read. The walker makes exactly one 64-bit read per level through a request/response port and keeps only one read in flight. The same datapath works for an ordinary translation root and for a nested (second-stage) root, because every entry address it forms has its upper twelve bits cleared.

A client drives the root, the mode bit and the address, then pulses start while the walker is idle. The walker reports its outcome with a one-cycle done pulse. That outcome is either a physical address, or a fault that names the level whose entry was not present. Large pages, permission bits other than present, caching of translations and memory-type handling belong to other blocks.

Top module: `pt_walker`

## Requirements
- R1: In five-level mode the first read address is {12'b0, root[51:12], addr[56:48], 3'b000}, and this table is level 5.
- R2: In four-level mode the walk starts at level 4 with {12'b0, root[51:12], addr[47:39], 3'b000}. It makes at most four reads, and addr[56:48] has no effect on any request or on the result.
- R3: Each following table base is bits 51:12 of the entry just returned. Entry bits 63:52 and 11:1 have no effect, and every request address has bits 63:52 equal to zero.
- R4: Below the top table, level 4 is indexed by addr[47:39], level 3 by addr[38:30], level 2 by addr[29:21] and level 1 by addr[20:12], in that order. Each index is shifted left by three.
- R5: When the level-1 entry is present, done_o pulses for exactly one cycle with fault_o low and paddr_o = {entry[51:12], addr[11:0]}.
- R6: When bit 0 of a returned entry is 0, the walk stops at once. done_o pulses with fault_o high and fault_lvl_o set to that entry's level (5 for the top table in five-level mode, down to 1 for the last table), and no further read is issued.
- R7: req_valid_o stays high with a stable req_addr_o until req_ready_i is seen. After an accepted request, no new request appears until resp_valid_i has returned the entry.
- R8: A start pulse while busy is ignored. Root, mode and address are sampled only in the cycle a start is accepted.
- R9: After reset the walker is idle: busy_o, req_valid_o and done_o are low.
- R10: An accepted start makes busy_o and req_valid_o high in the next cycle. busy_o falls in the cycle done_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a walk (taken only when idle) |
| mode5_i | input | 1 | 1: five-level walk, 0: four-level walk |
| root_i | input | 64 | Root pointer; bits 51:12 give the first table base |
| vaddr_i | input | 57 | Address to translate |
| busy_o | output | 1 | A walk is in progress |
| req_valid_o | output | 1 | Memory read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 64 | Byte address of the entry to read |
| resp_valid_i | input | 1 | Read data valid |
| resp_data_i | input | 64 | Returned table entry |
| done_o | output | 1 | One-cycle pulse when a walk ends |
| fault_o | output | 1 | Walk ended on a non-present entry |
| fault_lvl_o | output | 3 | Level of the non-present entry |
| paddr_o | output | 52 | Translated physical address |

## Verification
The bench sweeps every top-table index in both depths. It also sweeps a fault at every level against several index patterns, with the upper nine address bits set in four-level mode. A walker that used the wrong slice there, or kept those bits in four-level mode, would produce request addresses that do not match. Returned entries carry junk in bits 63:52 and 11:1, so a design that leaked them into the next base or into the result would be caught. Ready stalls and response delays test request holding and the single-read rule. Start pulses given mid-walk with changed root, mode and address show whether a busy walker re-samples its inputs. Off-by-one level reporting or extra reads after a fault show up in fault_lvl_o and in a stray req_valid_o after done.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_ISSUE = 2'd1,
        WALK_WAIT  = 2'd2
    } walk_state_e;

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
    parameter int  IDX_W  = 9,
    parameter int  OFF_W  = 12,
    parameter int  LEVELS = 5,
    localparam int VA_W   = OFF_W + IDX_W * LEVELS,
    localparam int LVL_W  = $clog2(LEVELS + 1)
) (
    input  logic [VA_W-1:0]  vaddr_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [IDX_W-1:0] slice_w [LEVELS];

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_slice
            assign slice_w[g] = vaddr_i[OFF_W + IDX_W * g +: IDX_W];
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (int'(lvl_i) == k + 1) begin
                idx_o = slice_w[k];
            end
        end
    end

endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int  PA_W    = 52,
    parameter int  ADDR_W  = 64,
    parameter int  IDX_W   = 9,
    parameter int  OFF_W   = 12,
    localparam int BASE_W  = PA_W - OFF_W,
    localparam int SHIFT_W = OFF_W - IDX_W
) (
    input  logic [BASE_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [PA_W-1:0] phys_w;

    always_comb begin
        phys_w = {base_i, idx_i, {SHIFT_W{1'b0}}};
        addr_o = ADDR_W'(phys_w);
    end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int  PA_W   = 52,
    parameter int  DATA_W = 64,
    parameter int  IDX_W  = 9,
    parameter int  OFF_W  = 12,
    parameter int  LEVELS = 5,
    localparam int VA_W   = OFF_W + IDX_W * LEVELS,
    localparam int VA_S_W = VA_W - IDX_W,
    localparam int BASE_W = PA_W - OFF_W,
    localparam int LVL_W  = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode5_i,
    input  logic [BASE_W-1:0] root_base_i,
    input  logic [VA_W-1:0]   vaddr_i,
    input  logic              req_ready_i,
    input  logic              resp_valid_i,
    input  logic [DATA_W-1:0] resp_data_i,
    output logic              req_valid_o,
    output logic              busy_o,
    output logic [LVL_W-1:0]  lvl_o,
    output logic [BASE_W-1:0] base_o,
    output logic [VA_W-1:0]   va_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [LVL_W-1:0]  fault_lvl_o,
    output logic [PA_W-1:0]   paddr_o
);

    typedef struct packed {
        walk_state_e       st;
        logic [LVL_W-1:0]  lvl;
        logic [BASE_W-1:0] base;
        logic [VA_W-1:0]   va;
        logic              done;
        logic              fault;
        logic [LVL_W-1:0]  flvl;
        logic [PA_W-1:0]   paddr;
    } ctrl_s;

    ctrl_s q, d;

    logic              present_w;
    logic [BASE_W-1:0] next_base_w;
    logic              unused_bits;

    assign present_w   = resp_data_i[0];
    assign next_base_w = resp_data_i[PA_W-1:OFF_W];
    assign unused_bits = ^{resp_data_i[DATA_W-1:PA_W], resp_data_i[OFF_W-1:1]};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            WALK_IDLE: begin
                if (start_i) begin
                    d.st   = WALK_ISSUE;
                    d.base = root_base_i;
                    if (mode5_i) begin
                        d.lvl = LVL_W'(LEVELS);
                        d.va  = vaddr_i;
                    end else begin
                        d.lvl = LVL_W'(LEVELS - 1);
                        d.va  = {{IDX_W{1'b0}}, vaddr_i[VA_S_W-1:0]};
                    end
                end
            end
            WALK_ISSUE: begin
                if (req_ready_i) begin
                    d.st = WALK_WAIT;
                end
            end
            WALK_WAIT: begin
                if (resp_valid_i) begin
                    if (!present_w) begin
                        d.st    = WALK_IDLE;
                        d.done  = 1'b1;
                        d.fault = 1'b1;
                        d.flvl  = q.lvl;
                        d.paddr = '0;
                    end else if (q.lvl == LVL_W'(1)) begin
                        d.st    = WALK_IDLE;
                        d.done  = 1'b1;
                        d.fault = 1'b0;
                        d.flvl  = '0;
                        d.paddr = {next_base_w, q.va[OFF_W-1:0]};
                    end else begin
                        d.st   = WALK_ISSUE;
                        d.lvl  = q.lvl - LVL_W'(1);
                        d.base = next_base_w;
                    end
                end
            end
            default: begin
                d.st = WALK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: WALK_IDLE, lvl: '0, base: '0, va: '0, done: 1'b0,
                   fault: 1'b0, flvl: '0, paddr: '0};
        end else begin
            q <= d;
        end
    end

    assign req_valid_o = (q.st == WALK_ISSUE);
    assign busy_o      = (q.st != WALK_IDLE);
    assign lvl_o       = q.lvl;
    assign base_o      = q.base;
    assign va_o        = q.va;
    assign done_o      = q.done;
    assign fault_o     = q.fault;
    assign fault_lvl_o = q.flvl;
    assign paddr_o     = q.paddr;

    // R7
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && req_ready_i |=> !req_valid_o);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    va_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(va_o) || !busy_o);

    // R6
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == WALK_WAIT) && resp_valid_i && !resp_data_i[0]
        |=> done_o && fault_o && !req_valid_o && !busy_o);

    // R10
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o && req_valid_o);

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int  PA_W   = 52,
    parameter int  ADDR_W = 64,
    parameter int  DATA_W = 64,
    parameter int  IDX_W  = 9,
    parameter int  OFF_W  = 12,
    parameter int  LEVELS = 5,
    localparam int VA_W   = OFF_W + IDX_W * LEVELS,
    localparam int LVL_W  = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode5_i,
    input  logic [ADDR_W-1:0] root_i,
    input  logic [VA_W-1:0]   vaddr_i,
    output logic              busy_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    input  logic              resp_valid_i,
    input  logic [DATA_W-1:0] resp_data_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [LVL_W-1:0]  fault_lvl_o,
    output logic [PA_W-1:0]   paddr_o
);

    localparam int BASE_W = PA_W - OFF_W;

    logic [LVL_W-1:0]  lvl_w;
    logic [BASE_W-1:0] base_w;
    logic [VA_W-1:0]   va_w;
    logic [IDX_W-1:0]  idx_w;
    logic              unused_root;

    assign unused_root = ^{root_i[ADDR_W-1:PA_W], root_i[OFF_W-1:0]};

    ptw_ctrl #(
        .PA_W   (PA_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .LEVELS (LEVELS)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode5_i      (mode5_i),
        .root_base_i  (root_i[PA_W-1:OFF_W]),
        .vaddr_i      (vaddr_i),
        .req_ready_i  (req_ready_i),
        .resp_valid_i (resp_valid_i),
        .resp_data_i  (resp_data_i),
        .req_valid_o  (req_valid_o),
        .busy_o       (busy_o),
        .lvl_o        (lvl_w),
        .base_o       (base_w),
        .va_o         (va_w),
        .done_o       (done_o),
        .fault_o      (fault_o),
        .fault_lvl_o  (fault_lvl_o),
        .paddr_o      (paddr_o)
    );

    ptw_index_sel #(
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .LEVELS (LEVELS)
    ) i_index_sel (
        .vaddr_i (va_w),
        .lvl_i   (lvl_w),
        .idx_o   (idx_w)
    );

    ptw_entry_addr #(
        .PA_W   (PA_W),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W)
    ) i_entry_addr (
        .base_i (base_w),
        .idx_i  (idx_w),
        .addr_o (req_addr_o)
    );

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !req_valid_o);

endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, mode5_i;
    logic [63:0] root_i;
    logic [56:0] vaddr_i;
    logic        busy_o, req_valid_o, req_ready_i;
    logic [63:0] req_addr_o;
    logic        resp_valid_i;
    logic [63:0] resp_data_i;
    logic        done_o, fault_o;
    logic [2:0]  fault_lvl_o;
    logic [51:0] paddr_o;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode5_i(mode5_i),
        .root_i(root_i), .vaddr_i(vaddr_i), .busy_o(busy_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_addr_o(req_addr_o), .resp_valid_i(resp_valid_i),
        .resp_data_i(resp_data_i), .done_o(done_o), .fault_o(fault_o),
        .fault_lvl_o(fault_lvl_o), .paddr_o(paddr_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory content: junk in bits 63:52 and 11:1, derived base in 51:12.
    function automatic logic [63:0] entry_of(input logic [63:0] a, input bit p);
        logic [39:0] nb;
        nb = a[51:12] ^ {a[11:3], 31'h2A5C3E19};
        return {12'hFA5, nb, 11'h7FE, p};
    endfunction

    task automatic walk(input bit m5, input logic [63:0] root, input logic [56:0] va,
                        input int inj, input int stall, input int lat, input bit poke);
        logic [39:0] base;
        logic [63:0] exp_addr, ent, held;
        logic [8:0]  idx;
        int          top;
        bit          p;
        string       tag;
        top  = m5 ? 5 : 4;
        base = root[51:12];
        @(negedge clk);
        start_i = 1'b1; mode5_i = m5; root_i = root; vaddr_i = va;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R10 busy after start", 64'(busy_o), 64'd1);
        for (int lv = top; lv >= 1; lv--) begin
            idx      = va[12 + 9 * (lv - 1) +: 9];
            exp_addr = {12'h000, base, idx, 3'b000};
            if (lv == 5) tag = "R1 top entry address";
            else if (lv == 4 && !m5) tag = "R2 four-level start address";
            else tag = "R4 R3 lower-level address";
            chk(req_valid_o === 1'b1 && req_addr_o === exp_addr, tag, req_addr_o, exp_addr);
            held = req_addr_o;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(req_valid_o === 1'b1 && req_addr_o === held, "R7 request held",
                    req_addr_o, held);
            end
            req_ready_i = 1'b1;
            @(negedge clk);
            req_ready_i = 1'b0;
            for (int w = 0; w < lat; w++) begin
                chk(req_valid_o === 1'b0, "R7 single outstanding", 64'(req_valid_o), 64'd0);
                if (poke) begin
                    start_i = 1'b1; mode5_i = ~m5; root_i = ~root; vaddr_i = ~va;
                end
                @(negedge clk);
                start_i = 1'b0;
            end
            p   = (lv != inj);
            ent = entry_of(exp_addr, p);
            resp_valid_i = 1'b1; resp_data_i = ent;
            @(negedge clk);
            resp_valid_i = 1'b0; resp_data_i = 64'hDEAD_BEEF_0000_0000;
            if (!p) begin
                chk(done_o === 1'b1 && fault_o === 1'b1 && fault_lvl_o === 3'(lv),
                    "R6 fault report", {fault_lvl_o, fault_o, done_o}, {3'(lv), 2'b11});
                break;
            end
            if (lv == 1) begin
                chk(done_o === 1'b1 && fault_o === 1'b0 && paddr_o === {ent[51:12], va[11:0]},
                    "R5 translated address", {fault_o, done_o, paddr_o},
                    {2'b01, ent[51:12], va[11:0]});
                chk(busy_o === 1'b0, "R10 busy falls with done", 64'(busy_o), 64'd0);
            end
            base = ent[51:12];
        end
        @(negedge clk);
        chk(done_o === 1'b0 && req_valid_o === 1'b0, "R6 R5 pulse ends, no extra read",
            {req_valid_o, done_o}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [56:0] va;
        logic [8:0]  pats [4];
        pats[0] = 9'h000; pats[1] = 9'h1FF; pats[2] = 9'h155; pats[3] = 9'h0AA;
        rst_n = 1'b0; start_i = 1'b0; mode5_i = 1'b0; root_i = '0; vaddr_i = '0;
        req_ready_i = 1'b0; resp_valid_i = 1'b0; resp_data_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o === 1'b0 && req_valid_o === 1'b0 && done_o === 1'b0, "R9 reset state",
            {busy_o, req_valid_o, done_o}, 64'd0);

        // Full walks: both depths, fault at every level, several index patterns.
        for (int m = 0; m < 2; m++) begin
            for (int inj = 0; inj <= 5; inj++) begin
                if (m == 0 && inj == 5) continue;
                for (int pi = 0; pi < 4; pi++) begin
                    for (int lv = 1; lv <= 5; lv++) va[12 + 9 * (lv - 1) +: 9] = pats[pi] ^ 9'(lv);
                    va[11:0] = 12'hABC ^ 12'(pi);
                    if (m == 0) va[56:48] = 9'h1FF;  // R2: must have no effect
                    walk(m == 1, 64'hFFF0_1234_5678_9FFF ^ 64'(pi << 20), va, inj,
                         pi % 3, (pi + 1) % 3, pi[0]);
                end
            end
        end

        // Exhaustive top-table index sweep, five-level (R1).
        for (int i = 0; i < 512; i++) begin
            va = {9'(i), 48'h0000_1111_2222};
            walk(1'b1, 64'h000A_BCDE_F012_3000, va, 5, 0, 0, 1'b0);
        end
        // Exhaustive first index sweep, four-level, upper bits set (R2).
        for (int i = 0; i < 512; i++) begin
            va = {9'(~i), 9'(i), 39'h12_3456_789A};
            walk(1'b0, 64'h0003_3333_4444_5000, va, 4, 0, 0, 1'b0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule